// File: doc/BRIEF.md
# Configurable Multi-Bank Chip-Select Decoder

This block turns a 30-bit byte address into one of eight active-low chip selects across a 1 GB space. The space is cut into eight 128 MB slots. The six lower slots each map to one bank at a fixed place. The top two slots form a 256 MB upper window. That window holds two banks of equal, programmable size, and the second one starts right where the first one ends.

A small register port holds two pieces of configuration. The first is a per-bank attribute word, with four bits per bank for data width, wait enable and byte-lane mode. The second is the upper-bank size code. For each valid access the block outputs the one-hot chip select and the attributes of the selected bank. An access that lands in the upper window past the end of the second upper bank raises a miss flag instead of a chip select. The bank-0 attributes are not writable: the width comes from a 2-bit strap pin. Bus timing and memory command generation belong to other blocks.

Top module: `bank_select_decoder`

## Requirements
- R1: With `acc_valid` high and `addr[29:27]` = k for k in 0..5, only `cs_n[k]` is low, at any offset within the slot.
- R2: Upper size code `size_code` (register 1, bits [2:0]) sets the size S of each upper bank: 100=2 MB, 101=4 MB, 110=8 MB, 111=16 MB, 000=32 MB, 001=64 MB, 010=128 MB. Bank 6 covers 0x3000_0000 up to 0x3000_0000+S-1, and bank 7 covers the next S bytes.
- R3: An access in the upper window (`addr[29:28]`=11) above the end of bank 7 drives all `cs_n` high and `decode_miss` high. Size code 011 is reserved, and under it every upper-window access misses.
- R4: At most one `cs_n` bit is low at any time. While `acc_valid` is low, all `cs_n` are high and `decode_miss` is low.
- R5: Register 0 holds a 4-bit field per bank k at bits [4k+3:4k]: bit 3 is the lane mode (1 = upper/lower byte enables, 0 = per-byte write enables), bit 2 is wait enable, and bits [1:0] are the width (00=8, 01=16, 10=32, 11 reserved). The selected bank's field drives `bank_lane`, `bank_wait` and `bank_width`. All three outputs are 0 when no bank is selected.
- R6: The bank-0 field always reads as {2'b00, `strap_w0`} and cannot be written. When bank 0 is selected, `bank_width` equals `strap_w0` (00=NAND, 01=16-bit, 10=32-bit, 11=test).
- R7: A write with `cfg_wr` high takes effect at the next rising clock edge. `cfg_rdata` returns register 0 when `cfg_sel`=0, and {29'b0, size_code} when `cfg_sel`=1. Bits [31:3] written to register 1 are ignored.
- R8: After reset, register 0 reads as {28'b0, 2'b00, `strap_w0`} and the size code is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 30 | Byte address of the access |
| acc_valid | input | 1 | Access strobe |
| cfg_wr | input | 1 | Register write enable |
| cfg_sel | input | 1 | Register select: 0 attribute word, 1 size code |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the selected register |
| strap_w0 | input | 2 | Bank-0 width strap |
| cs_n | output | 8 | Active-low chip selects |
| bank_width | output | 2 | Width code of the selected bank |
| bank_wait | output | 1 | Wait enable of the selected bank |
| bank_lane | output | 1 | Byte-lane mode of the selected bank |
| decode_miss | output | 1 | Access in the upper window beyond bank 7 |

## Verification
The bench probes the edges of the upper window for every size code: the first and last byte of bank 6, the first and last byte of bank 7, and the first byte past bank 7. An off-by-one boundary would select the wrong upper bank or miss the miss flag. A decoder that treated the window as two fixed 128 MB slots would select bank 7 where a miss is due. The bench also writes ones over the bank-0 field to catch a design that lets software override the strap. It reads registers back just before and just after the write edge, so a write that lands a cycle early or late shows up. A reserved size code that selected a bank would be reported as a false chip select.

// File: rtl/bank_select_decoder.sv
module bank_select_decoder #(
  parameter int ADDR_W = 30,
  parameter int NBANK  = 8,
  parameter int MIN_LG = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              acc_valid,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [1:0]        strap_w0,
  output logic [NBANK-1:0]  cs_n,
  output logic [1:0]        bank_width,
  output logic              bank_wait,
  output logic              bank_lane,
  output logic              decode_miss
);
  localparam int SLOT_LSB = ADDR_W - 3;
  localparam int OFF_W    = ADDR_W - 2;

  logic [31:4] attr_q;
  logic [2:0]  size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
      size_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_sel) size_q <= cfg_wdata[2:0];
      else         attr_q <= cfg_wdata[31:4];
    end
  end

  logic [31:0] attr_all;
  assign attr_all  = {attr_q, 2'b00, strap_w0};
  assign cfg_rdata = cfg_sel ? {29'd0, size_q} : attr_all;

  logic [2:0]        slot;
  logic [2:0]        lg;
  logic              upper, rsv;
  logic [ADDR_W-1:0] off_ext, span;
  logic              in6, in7;

  assign slot    = addr[ADDR_W-1:SLOT_LSB];
  assign upper   = slot[2] & slot[1];
  assign lg      = {~size_q[2], size_q[1:0]};
  assign rsv     = (lg == 3'd7);
  assign off_ext = {2'b00, addr[OFF_W-1:0]};
  assign span    = ADDR_W'(1) << (MIN_LG + int'(lg));
  assign in6     = off_ext < span;
  assign in7     = !in6 && (off_ext < (span << 1));

  logic       hit;
  logic [2:0] idx;

  always_comb begin
    hit = 1'b0;
    idx = slot;
    if (acc_valid) begin
      if (!upper) hit = 1'b1;
      else if (!rsv && in6) begin hit = 1'b1; idx = 3'd6; end
      else if (!rsv && in7) begin hit = 1'b1; idx = 3'd7; end
    end
  end

  logic [3:0] fld;
  assign fld         = attr_all[{idx, 2'b00} +: 4];
  assign cs_n        = ~(hit ? (NBANK'(1) << idx) : NBANK'(0));
  assign bank_width  = hit ? fld[1:0] : 2'b00;
  assign bank_wait   = hit & fld[2];
  assign bank_lane   = hit & fld[3];
  assign decode_miss = acc_valid & upper & ~hit;

  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (&cs_n && !decode_miss));
  a_r3_miss_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    decode_miss |-> &cs_n);
  a_r1_low_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && addr[ADDR_W-1:SLOT_LSB] < 3'd6) |-> (cs_n[addr[ADDR_W-1:SLOT_LSB]] == 1'b0));
  a_r6_bank0_strap: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n[0] |-> (bank_width == strap_w0));
  a_r7_size_update: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel) |=> (size_q == $past(cfg_wdata[2:0])));
endmodule

// File: tb/sim_bank_select_decoder.sv
`timescale 1ns/1ps
module sim_bank_select_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] addr = '0;
  logic        acc_valid = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  strap_w0 = 2'b10;
  logic [7:0]  cs_n;
  logic [1:0]  bank_width;
  logic        bank_wait, bank_lane, decode_miss;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  bank_select_decoder u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input string tag, input logic [29:0] a, input int bank);
    @(negedge clk);
    addr = a; acc_valid = 1'b1;
    #2;
    if (bank >= 0) chk({tag, " cs"}, {24'd0, cs_n}, {24'd0, ~(8'd1 << bank)});
    else           chk({tag, " cs"}, {24'd0, cs_n}, 32'hFF);
    chk({tag, " miss"}, {31'd0, decode_miss}, {31'd0, bank == -1});
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    cfg_sel = 1'b0; #2;
    chk("R8 attr reset", cfg_rdata, 32'h2);
    cfg_sel = 1'b1; #2;
    chk("R8 size reset", cfg_rdata, 32'h0);
    acc_valid = 1'b0; addr = 30'h0; #2;
    chk("R4 idle cs", {24'd0, cs_n}, 32'hFF);
    chk("R4 idle miss", {31'd0, decode_miss}, 32'h0);
  endtask

  task automatic t_fixed;
    for (int k = 0; k < 6; k++) begin
      access("R1 slot base", 30'(k) << 27, k);
      access("R1 slot top", (30'(k) << 27) | 30'h7FF_FFFF, k);
    end
  endtask

  function automatic int lg_of(input logic [2:0] c);
    case (c)
      3'b100: return 0;
      3'b101: return 1;
      3'b110: return 2;
      3'b111: return 3;
      3'b000: return 4;
      3'b001: return 5;
      default: return 6;
    endcase
  endfunction

  task automatic t_upper;
    logic [2:0] codes [7] = '{3'b100, 3'b101, 3'b110, 3'b111, 3'b000, 3'b001, 3'b010};
    for (int i = 0; i < 7; i++) begin
      logic [29:0] s;
      s = 30'd1 << (21 + lg_of(codes[i]));
      wr(1'b1, {29'd0, codes[i]});
      access("R2 b6 first", 30'h3000_0000, 6);
      access("R2 b6 last", 30'h3000_0000 + s - 1, 6);
      access("R2 b7 first", 30'h3000_0000 + s, 7);
      access("R2 b7 last", 30'h3000_0000 + 2*s - 1, 7);
      if (2*s < 30'h1000_0000) access("R3 past b7", 30'h3000_0000 + 2*s, -1);
      access("R3 window top", 30'h3FFF_FFFF, (2*s < 30'h1000_0000) ? -1 : 7);
    end
    wr(1'b1, 32'h3);
    access("R3 reserved base", 30'h3000_0000, -1);
    access("R3 reserved top", 30'h3800_0000, -1);
  endtask

  task automatic t_attr;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'hFEDC_BA9F;
    #2;
    chk("R7 before edge", cfg_rdata, 32'h2);
    @(negedge clk);
    cfg_wr = 1'b0; #2;
    chk("R7 after edge", cfg_rdata, 32'hFEDC_BA92);
    chk("R6 bank0 locked", {28'd0, cfg_rdata[3:0]}, 32'h2);
    access("R5 bank3", 30'h1800_0000, 3);
    chk("R5 b3 attrs", {28'd0, bank_lane, bank_wait, bank_width}, 32'hB);
    access("R5 bank1", 30'h0800_0010, 1);
    chk("R5 b1 attrs", {28'd0, bank_lane, bank_wait, bank_width}, 32'h9);
    access("R5 bank5", 30'h2800_0000, 5);
    chk("R5 b5 attrs", {28'd0, bank_lane, bank_wait, bank_width}, 32'hD);
    access("R6 bank0", 30'h0000_0004, 0);
    chk("R6 b0 attrs", {28'd0, bank_lane, bank_wait, bank_width}, 32'h2);
    @(negedge clk); strap_w0 = 2'b01; #2;
    chk("R6 strap follow", {30'd0, bank_width}, 32'h1);
    wr(1'b1, 32'hFFFF_FFF9);
    cfg_sel = 1'b1; #2;
    chk("R7 size readback", cfg_rdata, 32'h1);
    access("R5 bank7", 30'h3400_0000, 7);
    chk("R5 b7 attrs", {28'd0, bank_lane, bank_wait, bank_width}, 32'hF);
    access("R5 miss attrs", 30'h3800_0000, -1);
    chk("R5 miss zero", {28'd0, bank_lane, bank_wait, bank_width}, 32'h0);
    @(negedge clk); acc_valid = 1'b0; #2;
    chk("R4 idle after", {23'd0, decode_miss, cs_n}, 32'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed();
    t_upper();
    t_attr();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule